// File: doc/BRIEF.md
# Signed Integer Multiply-Accumulate with Doubled Half-Word Writeback

This block multiplies one signed 16-bit half of each of two 32-bit source words as integers. It then loads the product into a 40-bit accumulator, adds it to the accumulator or subtracts it from it. A per-operand select picks the low or the high half of each source. The product is taken as a plain integer, with no fractional alignment shift.

After each operation, the updated accumulator is doubled and clamped to a signed 16-bit range. That value replaces the low half of a destination word supplied by the caller. The upper half of that word passes through unchanged. The low 32 bits of the accumulator are always visible on a read port.

An operation is presented for one cycle with `opValid`, and its results appear on the next cycle. A clear input zeroes the accumulator. The clear can arrive on its own, or in the same cycle as an operation, which then starts from zero.

Top module: `imac_half_wb`

## Requirements
- R1: `selA`/`selB` choose the operand half: 0 takes bits [15:0], 1 takes bits [31:16] of `srcA`/`srcB` respectively.
- R2: Mode 2'b00 (and the unused code 2'b11) loads the accumulator with the signed 16x16 integer product, sign-extended to 40 bits, with no left shift.
- R3: Mode 2'b01 adds the sign-extended product to the accumulator.
- R4: Mode 2'b10 subtracts the sign-extended product from the accumulator.
- R5: The accumulator is 40 bits wide and wraps modulo 2^40 on add and subtract, with no saturation.
- R6: The low 16 bits of `resDst` equal twice the updated 40-bit accumulator, clamped to signed 16 bits: 0x7FFF above the range, 0x8000 below it, and the exact value inside it. No fractional bits are dropped, so rounding adds nothing.
- R7: Bits [31:16] of `resDst` equal bits [31:16] of `dstPrior` from the operation's cycle.
- R8: `accLow` shows accumulator bits [31:0] one cycle after any operation or clear.
- R9: `accClear` without `opValid` sets the accumulator to zero. It raises no `resValid` and leaves `resDst` unchanged.
- R10: `accClear` together with `opValid` applies the operation to a zero accumulator.
- R11: `resValid` is high exactly one cycle after `opValid`. When no operation occurs, `resDst` and the accumulator hold their values.
- R12: After reset, `resValid` is 0, and `resDst` and `accLow` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opMode | input | 2 | 00 load, 01 add, 10 subtract, 11 load |
| selA | input | 1 | Half select for srcA (0 low, 1 high) |
| selB | input | 1 | Half select for srcB (0 low, 1 high) |
| accClear | input | 1 | Zero the accumulator before any operation this cycle |
| srcA | input | 32 | First source word |
| srcB | input | 32 | Second source word |
| dstPrior | input | 32 | Prior value of the destination word |
| resValid | output | 1 | resDst holds a new result |
| resDst | output | 32 | Destination word with the new low half |
| accLow | output | 32 | Accumulator bits [31:0] |

## Verification
A corrupted accumulator shows on `accLow` on the cycle after the operation that corrupts it. It also shows in the low half of `resDst`, unless the doubled value is already clamped to 0x7FFF or 0x8000. Damage confined to accumulator bits [39:32] stays hidden from `accLow`. It appears only through the saturation decision, so the bench runs a long chain of full-scale additions that wraps the accumulator exactly to zero. A wrong half select or a wrong mode shows on the next cycle. The bench also replays known products and clamped results to confirm sign handling.

// File: rtl/imac_pkg.sv
package imac_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD  = 2'b00,
    MODE_ADD   = 2'b01,
    MODE_SUB   = 2'b10,
    MODE_LOAD2 = 2'b11
  } macMode_e;

  typedef struct packed {
    logic accWe;     // accumulator register updates this cycle
    logic zeroBase;  // start from zero rather than the held accumulator
    logic applyProd; // fold the product into the base
    logic subtract;  // negate the product before folding
    logic resWe;     // capture a new destination word
  } macStrobes_t;
endpackage

// File: rtl/imac_ctrl.sv
module imac_ctrl
  import imac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [1:0]  opMode,
  input  logic        accClear,
  output macStrobes_t strobes
);
  macMode_e modeSel;

  always_comb begin
    modeSel            = macMode_e'(opMode);
    strobes.accWe      = opValid | accClear;
    strobes.applyProd  = opValid;
    strobes.resWe      = opValid;
    strobes.subtract   = opValid && (modeSel == MODE_SUB);
    strobes.zeroBase   = accClear ||
                         (opValid && (modeSel == MODE_LOAD || modeSel == MODE_LOAD2));
  end

  // R11: a capture happens exactly when an operation is presented
  assert_res_we_tracks_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.resWe == opValid);

  // R9: a lone clear writes the accumulator but never the destination
  assert_clear_only_no_res_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accClear && !opValid) |-> (strobes.accWe && !strobes.resWe && strobes.zeroBase));
endmodule

// File: rtl/imac_datapath.sv
module imac_datapath
  import imac_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ACC_W       = 40,
  parameter int ROUND_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  macStrobes_t       strobes,
  input  logic              selA,
  input  logic              selB,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] dstPrior,
  output logic              resValid,
  output logic [WORD_W-1:0] resDst,
  output logic [WORD_W-1:0] accLow
);
  localparam int HALF_W = WORD_W / 2;
  localparam int PROD_W = 2 * HALF_W;
  localparam int DBL_W  = ACC_W + 1;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [HALF_W-1:0] opA, opB;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt, prodSigned, accBase, accNext, accQ;
  logic signed [DBL_W-1:0]  dbl, scaled;
  logic [HALF_W-1:0]        satHalf;
  logic [DBL_W-HALF_W:0]    topBits;

  // Operand half selection
  always_comb begin
    opA = selA ? srcA[WORD_W-1:HALF_W] : srcA[HALF_W-1:0];
    opB = selB ? srcB[WORD_W-1:HALF_W] : srcB[HALF_W-1:0];
  end

  // Integer product, sign-extended into accumulator width
  always_comb begin
    prod       = opA * opB;
    prodExt    = {{EXT_W{prod[PROD_W-1]}}, prod};
    prodSigned = strobes.subtract ? -prodExt : prodExt;
    accBase    = strobes.zeroBase ? '0 : accQ;
    accNext    = strobes.applyProd ? accBase + prodSigned : accBase;
  end

  // Doubling and optional rounding of dropped bits
  assign dbl = {accNext, 1'b0};

  generate
    if (ROUND_SHIFT == 0) begin : g_noRound
      assign scaled = dbl;
    end else begin : g_round
      assign scaled = (dbl + (DBL_W'(1) <<< (ROUND_SHIFT - 1))) >>> ROUND_SHIFT;
    end
  endgenerate

  // Clamp to signed half-word
  always_comb begin
    topBits = scaled[DBL_W-1:HALF_W-1];
    if (topBits == '0 || topBits == '1)
      satHalf = scaled[HALF_W-1:0];
    else if (scaled[DBL_W-1])
      satHalf = {1'b1, {(HALF_W-1){1'b0}}};
    else
      satHalf = {1'b0, {(HALF_W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ     <= '0;
      resDst   <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strobes.resWe;
      if (strobes.accWe) accQ <= accNext;
      if (strobes.resWe) resDst <= {dstPrior[WORD_W-1:HALF_W], satHalf};
    end
  end

  assign accLow = accQ[WORD_W-1:0];

  // R7: upper half of the result comes from the prior destination word
  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resValid) |-> resDst[WORD_W-1:HALF_W] == $past(dstPrior[WORD_W-1:HALF_W]));

  // R11: idle cycles leave accumulator and destination untouched
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.accWe |=> ($stable(accLow) && $stable(resDst)));

  // R9: a clear with no operation leaves a zero accumulator
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.zeroBase && !strobes.applyProd) |=> (accLow == '0));

  // R6: a result that fits the range leaves the top half-word bits in agreement
  assert_sat_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.resWe && !accNext[ACC_W-1] && accNext < ACC_W'(1) <<< (HALF_W - 2))
      |=> !resDst[HALF_W-1]);
endmodule

// File: rtl/imac_half_wb.sv
module imac_half_wb
  import imac_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int ACC_W       = 40,
  parameter int ROUND_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [1:0]        opMode,
  input  logic              selA,
  input  logic              selB,
  input  logic              accClear,
  input  logic [WORD_W-1:0] srcA,
  input  logic [WORD_W-1:0] srcB,
  input  logic [WORD_W-1:0] dstPrior,
  output logic              resValid,
  output logic [WORD_W-1:0] resDst,
  output logic [WORD_W-1:0] accLow
);
  macStrobes_t strobes;

  imac_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opMode   (opMode),
    .accClear (accClear),
    .strobes  (strobes)
  );

  imac_datapath #(
    .WORD_W      (WORD_W),
    .ACC_W       (ACC_W),
    .ROUND_SHIFT (ROUND_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .selA     (selA),
    .selB     (selB),
    .srcA     (srcA),
    .srcB     (srcB),
    .dstPrior (dstPrior),
    .resValid (resValid),
    .resDst   (resDst),
    .accLow   (accLow)
  );

  // R11: result strobe follows the operation strobe by one cycle
  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(opValid) |-> resValid);
endmodule

// File: tb/imac_half_wb_tb.sv
module imac_half_wb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic        selA = 1'b0, selB = 1'b0, accClear = 1'b0;
  logic [31:0] srcA = '0, srcB = '0, dstPrior = '0;
  logic        resValid;
  logic [31:0] resDst, accLow;

  int checks = 0;
  int errors = 0;
  logic signed [39:0] mAcc = '0;
  logic [31:0]        mDst = '0;
  bit                 done = 1'b0;

  always #5 clk = ~clk;

  imac_half_wb u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opMode(opMode),
    .selA(selA), .selB(selB), .accClear(accClear), .srcA(srcA), .srcB(srcB),
    .dstPrior(dstPrior), .resValid(resValid), .resDst(resDst), .accLow(accLow)
  );

  function automatic logic [15:0] clampDbl(input logic signed [39:0] a);
    logic signed [40:0] d;
    d = {a, 1'b0};
    if (d > 41'sd32767) return 16'h7FFF;
    if (d < -41'sd32768) return 16'h8000;
    return d[15:0];
  endfunction

  function automatic logic signed [39:0] prodOf(input logic [31:0] a, input logic [31:0] b,
                                                input logic sa, input logic sb);
    logic signed [15:0] ha, hb;
    logic signed [31:0] p;
    ha = sa ? a[31:16] : a[15:0];
    hb = sb ? b[31:16] : b[15:0];
    p = ha * hb;
    return 40'(p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one cycle of stimulus at a falling edge, check after the next rising edge.
  task automatic doOp(input logic v, input logic [1:0] m, input logic sa, input logic sb,
                      input logic clr, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] pr, input string req);
    logic signed [39:0] p;
    opValid = v; opMode = m; selA = sa; selB = sb; accClear = clr;
    srcA = a; srcB = b; dstPrior = pr;
    p = prodOf(a, b, sa, sb);
    if (clr) mAcc = '0;
    if (v) begin
      case (m)
        2'b01:   mAcc = mAcc + p;
        2'b10:   mAcc = mAcc - p;
        default: mAcc = p;
      endcase
      mDst = {pr[31:16], clampDbl(mAcc)};
    end
    @(negedge clk);
    check({req, " valid"}, {31'd0, resValid}, {31'd0, v});
    check({req, " dst"}, resDst, mDst);
    check({req, " accLow"}, accLow, mAcc[31:0]);
    opValid = 1'b0; accClear = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", {31'd0, resValid}, 32'd0);
    check("R12 dst", resDst, 32'd0);
    check("R12 accLow", accLow, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6 R7: known product, negative overflow clamps to 0x8000
    doOp(1, 2'b00, 0, 0, 0, 32'h7fbcfec7, 32'hf3545abd, 32'hf3545abd, "R2");
    check("R2 known product", accLow, 32'hFF910EEB);
    check("R6 neg clamp", resDst, 32'hF3548000);
    // R1 R4: high half of A, low half of B, subtract
    doOp(1, 2'b10, 1, 0, 0, 32'hc7fff679, 32'hd0799007, 32'hc7fff679, "R4");
    check("R4 known subtract", accLow, 32'hE71226F2);
    // R1: both high halves, add
    doOp(1, 2'b01, 1, 1, 0, 32'hefb79f69, 32'hcd35700b, 32'h12345678, "R3");
    // R11: idle cycles hold everything
    doOp(0, 2'b01, 0, 0, 0, 32'hffffffff, 32'hffffffff, 32'hdeadbeef, "R11 idle");
    doOp(0, 2'b10, 1, 1, 0, 32'h7fff7fff, 32'h7fff7fff, 32'h0, "R11 idle");
    // R9: clear only
    doOp(0, 2'b01, 0, 0, 1, 32'h7fff7fff, 32'h7fff7fff, 32'h55555555, "R9 clear");
    check("R9 acc zero", accLow, 32'd0);
    // R6: in-range exact doubling, and positive clamp
    doOp(1, 2'b01, 0, 0, 0, 32'h00000003, 32'h0000fffb, 32'habcd0000, "R6 exact");
    check("R6 exact value", resDst, 32'habcdffe2);
    doOp(1, 2'b00, 0, 0, 0, 32'h00007fff, 32'h00007fff, 32'h11110000, "R6 pos");
    check("R6 pos clamp", resDst, 32'h11117fff);
    // R2: unused mode code loads
    doOp(1, 2'b11, 0, 1, 0, 32'h00000002, 32'h00070000, 32'h0, "R2 mode3");
    check("R2 mode3 load", accLow, 32'd14);
    // R10: clear with add starts from zero
    doOp(1, 2'b01, 0, 0, 1, 32'h00000005, 32'h00000006, 32'h0, "R10");
    check("R10 clear+add", accLow, 32'd30);

    // R5: 1024 full-scale products wrap the 40-bit accumulator back to zero
    doOp(1, 2'b00, 0, 0, 1, 32'h00008000, 32'h00008000, 32'h0, "R5 seed");
    for (int i = 0; i < 1023; i++)
      doOp(1, 2'b01, 0, 0, 0, 32'h00008000, 32'h00008000, 32'h0, "R5 chain");
    check("R5 wrap to zero dst", resDst, 32'h00000000);

    // R3 R4 R8 R10: constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      doOp(r[0] | r[1], r[3:2], r[4], r[5], (r[9:6] == 4'd0),
           $urandom, $urandom, $urandom, "R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule